// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This peripheral watches for software that has stopped making progress in a small 8-bit controller. Software sets up the watchdog through one 8-bit control register. It turns the watchdog on, picks how fast the watchdog counts, and restarts the count at regular points in its main loop. If the restarts stop arriving, a 16-bit up-counter runs past its maximum and the block drives a reset pulse of fixed length back into the system.

The counter does not advance on every oscillator cycle. A free-running 10-bit divider produces a one-cycle advance strobe once every 8, 16, 32 and so on up to 1024 cycles, chosen by a 3-bit select. The whole design runs in the oscillator clock domain. From a restart, the timeout is therefore 65536 × divider oscillator cycles.

The enable bit is cleared by the external reset and also by the watchdog's own reset pulse. After either reset, software must turn the watchdog on again.

Top module: `wdog_top`

## Requirements
- R1: After the external reset is released, the control register reads 0x00 and `wdt_rst_o` is low.
- R2: A write to address 0x9F stores bit 7 as the enable and bits 2:0 as the divider select. A read of 0x9F returns the enable in bit 7 and the select in bits 2:0, with bits 6..3 as 0. A write to any other address changes nothing, and a read of any other address returns 0x00.
- R3: Writing 1 to bit 5 of the register at 0x9F zeroes the counter and the divider in the same edge. The bit is never stored and always reads back as 0.
- R4: The timeout scales with the select code. If enable and restart are written together in the edge E, with select s, `wdt_rst_o` rises right after edge E + 2^CNT_W × 2^(s+3). With the default CNT_W = 16 this is 65536 × 8 for s = 0 and 65536 × 1024 for s = 7.
- R5: While the enable is 0, the counter holds its value. When the enable is set again without a restart, counting resumes from the held value.
- R6: Each overflow drives `wdt_rst_o` high for exactly 4 cycles.
- R7: The watchdog reset pulse returns the register, the counter and the divider to zero. Writes made while the pulse is high are ignored.
- R8: If a restart is written in the same edge in which the counter would overflow, the restart wins and no reset pulse is issued.
- R9: An external reset clears the enable, so no timeout follows until software enables the watchdog again.
- R10: Restarts written at intervals shorter than the timeout keep `wdt_rst_o` low indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | External hardware reset, active low, asynchronous assert |
| reg_addr | input | 8 | Special-function register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| wdt_rst_o | output | 1 | Watchdog reset pulse, high for 4 cycles |

## Verification
Some properties are checked by assertions on every cycle:
- a restart zeroes the counter and the divider;
- a disabled counter holds its value;
- an enabled counter steps by exactly one on each strobe;
- the watchdog pulse clears the register;
- a restart is never followed by a rising reset output.

Other behaviour can only be shown by the bench's scenarios:
- the exact timeout for several select codes;
- the 4-cycle pulse width;
- the resume after a pause;
- a restart that collides with the overflow edge;
- the absence of a reset under periodic restarts or after an external reset.

The bench uses a narrowed counter width so that full overflows fit in its run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W   = 8;
  localparam int EN_BIT   = 7;
  localparam int CLR_BIT  = 5;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int          PS_W      = 3,
  parameter logic [7:0]  CTRL_ADDR = 8'h9F
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wd_rst,
  input  logic [DATA_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic              en,
  output logic [PS_W-1:0]   ps,
  output logic              clear,
  output logic [DATA_W-1:0] rdata
);
  logic            hit, wr;
  logic            en_q, en_d;
  logic [PS_W-1:0] ps_q, ps_d;

  assign hit   = (addr == CTRL_ADDR);
  assign wr    = we && hit && !wd_rst;
  assign clear = wr && wdata[CLR_BIT];

  always_comb begin
    en_d = en_q;
    ps_d = ps_q;
    if (wd_rst) begin
      en_d = 1'b0;
      ps_d = '0;
    end else if (wr) begin
      en_d = wdata[EN_BIT];
      ps_d = wdata[PS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      ps_q <= '0;
    end else begin
      en_q <= en_d;
      ps_q <= ps_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[EN_BIT]   = en_q;
      rdata[PS_W-1:0] = ps_q;
    end
  end

  assign en = en_q;
  assign ps = ps_q;

  // R2: an accepted write lands in the stored fields
  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (we && hit && !wd_rst) |=> (en_q == $past(wdata[EN_BIT]) && ps_q == $past(wdata[PS_W-1:0])));
  // R7: the watchdog pulse wipes the register
  assert_wdrst_clears_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    wd_rst |=> (!en_q && ps_q == '0));
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PS_W     = 3,
  parameter int MIN_LOG2 = 3
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            restart,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int TAPS  = 1 << PS_W;
  localparam int DIV_W = MIN_LOG2 + TAPS - 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic [TAPS-1:0]  tap_roll;

  always_comb begin
    if (restart) div_d = '0;
    else         div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign tap_roll[g] = &div_q[MIN_LOG2+g-1:0];
  end

  assign tick = tap_roll[ps];

  // R3: a restart puts the divider back to its start
  assert_div_restart_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    restart |=> (div_q == '0 && !tick));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic en,
  input  logic tick,
  input  logic clear,
  input  logic wd_rst,
  output logic ovf
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  assign step = en && tick;

  always_comb begin
    cnt_d = cnt_q;
    if (clear || wd_rst) cnt_d = '0;
    else if (step)       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign ovf = step && (&cnt_q) && !clear && !wd_rst;

  // R3: restart zeroes the count
  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (clear || wd_rst) |=> (cnt_q == '0));
  // R5: disabled counter keeps its value
  assert_halt_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (!en && !clear && !wd_rst) |=> $stable(cnt_q));
  // R4: one step per strobe while enabled
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (step && !clear && !wd_rst) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic ovf,
  output logic pulse
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (ovf)                 left_d = PW'(PULSE_LEN);
    else if (left_q != '0)   left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) left_q <= '0;
    else         left_q <= left_d;
  end

  assign pulse = (left_q != '0);

  // R6: the pulse only starts from an overflow
  assert_pulse_src_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(pulse) |-> $past(ovf));
endmodule

// File: rtl/wdog_top.sv
module wdog_top #(
  parameter int         CNT_W     = 16,
  parameter int         PS_W      = 3,
  parameter int         MIN_LOG2  = 3,
  parameter int         PULSE_LEN = 4,
  parameter logic [7:0] CTRL_ADDR = 8'h9F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_we,
  output logic [7:0] reg_rdata,
  output logic       wdt_rst_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_ni;
  logic            en, clear, tick, ovf;
  logic [PS_W-1:0] ps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  wdog_regs #(.PS_W(PS_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .wd_rst(wdt_rst_o),
    .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
    .en(en), .ps(ps), .clear(clear), .rdata(reg_rdata)
  );

  wdog_prescaler #(.PS_W(PS_W), .MIN_LOG2(MIN_LOG2)) u_div (
    .clk(clk), .rst_ni(rst_ni), .restart(clear || wdt_rst_o),
    .ps(ps), .tick(tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_ni(rst_ni), .en(en), .tick(tick),
    .clear(clear), .wd_rst(wdt_rst_o), .ovf(ovf)
  );

  wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_ni(rst_ni), .ovf(ovf), .pulse(wdt_rst_o)
  );

  // R8: a restart is never followed by a fresh reset pulse
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    clear |=> !$rose(wdt_rst_o));
endmodule

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
  localparam int CNT_W = 6;
  localparam int NCNT  = 1 << CNT_W;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we;
  logic       wdt_rst_o;

  int unsigned cyc = 0;
  int          checks = 0, failures = 0;
  int          rises = 0;
  int unsigned exp_cyc_q[$];
  string       exp_tag_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_top #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .wdt_rst_o(wdt_rst_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // driver: write so that it takes effect at edge number edge_no
  task automatic wr_at(input int unsigned edge_no, input logic [7:0] data,
                       input logic [7:0] addr = 8'h9F);
    while (cyc + 1 < edge_no) @(negedge clk);
    reg_addr = addr; reg_wdata = data; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wr_now(input logic [7:0] data, input logic [7:0] addr = 8'h9F);
    wr_at(cyc + 1, data, addr);
  endtask

  task automatic rd(input logic [7:0] addr, input logic [7:0] exp, input string req);
    reg_addr = addr;
    #1;
    check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic expect_rise(input int unsigned c, input string tag);
    exp_cyc_q.push_back(c);
    exp_tag_q.push_back(tag);
  endtask

  task automatic wait_until(input int unsigned c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: pops expected pulse starts and checks pulse width
  bit prev = 1'b0;
  int width = 0;
  always @(negedge clk) begin
    if (wdt_rst_o && !prev) begin
      rises++;
      width = 1;
      if (exp_cyc_q.size() == 0) check(1'b0, "R10/R9 unexpected reset", cyc, 0);
      else begin
        int unsigned e;
        string t;
        e = exp_cyc_q.pop_front();
        t = exp_tag_q.pop_front();
        check(cyc == e, t, cyc, e);
      end
    end else if (wdt_rst_o) width++;
    else if (prev) check(width == 4, "R6 pulse width", width, 4);
    prev = wdt_rst_o;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned e;
    int r0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h9F, 8'h00, "R1 reg after reset");
    check(wdt_rst_o == 1'b0, "R1 reset output low", wdt_rst_o, 0);

    // R2 register fields and address decode
    wr_now(8'h7F); rd(8'h9F, 8'h07, "R2 readback 0x7F");
    wr_now(8'hFF); rd(8'h9F, 8'h87, "R2 readback 0xFF");
    wr_now(8'h00); rd(8'h9F, 8'h00, "R2 readback 0x00");
    wr_now(8'h85, 8'h9E); rd(8'h9F, 8'h00, "R2 other address no effect");
    rd(8'h9E, 8'h00, "R2 other address reads zero");

    // R4 select 0, R7 write during pulse ignored
    wr_now(8'hA0); e = cyc;
    rd(8'h9F, 8'h80, "R3 clear bit not stored");
    expect_rise(e + NCNT * 8, "R4 timeout sel0");
    wr_at(e + NCNT * 8 + 1, 8'h87);
    wait_until(e + NCNT * 8 + 8);
    rd(8'h9F, 8'h00, "R7 reg cleared, write during pulse ignored");
    r0 = rises;
    wait_until(cyc + 700);
    check(rises == r0, "R7 no restart after watchdog reset", rises, r0);

    // R4 select 3
    wr_now(8'hA3); e = cyc;
    expect_rise(e + NCNT * 64, "R4 timeout sel3");
    wait_until(e + NCNT * 64 + 8);
    rd(8'h9F, 8'h00, "R7 reg cleared after sel3 timeout");

    // R4 select 7
    wr_now(8'hA7); e = cyc;
    expect_rise(e + NCNT * 1024, "R4 timeout sel7");
    wait_until(e + NCNT * 1024 + 8);

    // R10 periodic restarts
    wr_now(8'hA0); e = cyc;
    r0 = rises;
    for (int k = 0; k < 5; k++) begin
      wr_at(e + 300, 8'hA0); e = cyc;
    end
    check(rises == r0, "R10 no reset while restarting", rises, r0);
    expect_rise(e + NCNT * 8, "R10/R3 timeout from last restart");
    wait_until(e + NCNT * 8 + 8);

    // R5 pause keeps count
    wr_now(8'hA0); e = cyc;
    wr_at(e + 200, 8'h00);
    wr_at(e + 1000, 8'h80);
    expect_rise(e + 1000 + (NCNT - 25) * 8, "R5 resume from held count");
    wait_until(e + 1000 + (NCNT - 25) * 8 + 8);

    // R8 restart on the overflow edge wins
    wr_now(8'hA0); e = cyc;
    wr_at(e + NCNT * 8, 8'hA0);
    check(cyc == e + NCNT * 8, "R8 restart edge alignment", cyc, e + NCNT * 8);
    expect_rise(e + 2 * NCNT * 8, "R8 restart wins, later timeout");
    wait_until(e + 2 * NCNT * 8 + 8);

    // R9 external reset clears enable
    wr_now(8'hA0);
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    rd(8'h9F, 8'h00, "R9 enable cleared by external reset");
    r0 = rises;
    repeat (800) @(negedge clk);
    check(rises == r0, "R9 no timeout after external reset", rises, r0);

    check(exp_cyc_q.size() == 0, "R4 all expected pulses seen", exp_cyc_q.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule